// File: doc/BRIEF.md
# Seven-to-One Four-Lane Pixel Serializer

This block turns one 28-bit parallel word per word period into four serial bit streams. It runs on the fast bit clock. One word period is seven bit-clock cycles, so each lane carries seven bits per word. Every word holds two general-purpose output bits, the frame-valid and line-valid sync bits, and a 24-bit data channel. That channel can hold frame information, pixel data or line checksums. The sideband bits always take the lowest four slots of lane 0. The data bits fill the remaining slots of lane 0 and then lanes 1 to 3 in order.

A two-bit format input selects the data width: 8, 12, 16 or 24 bits. Data bits above the selected width are cleared. Lanes the format does not need are held low, so the receiver only sees activity on lanes that carry information. A separate marker output gives a 4:3 high/low pattern per word, aligned to the first serial bit. A receiver uses it to find word boundaries.

Upstream logic holds the word on the inputs. The block samples the inputs once per word period, on the edge where its internal slot counter is zero. The first such edge is the first rising edge after reset is released. Sampling repeats every seven cycles after that.

Top module: `pix_serializer`

## Requirements
- R1: The word period is exactly 7 bit-clock cycles. The inputs are sampled once per period. Input changes between two sample edges have no effect on the serial output of the current word.
- R2: Each lane shifts out its seven slots from slot 6 down to slot 0, one slot per cycle. Slot 6 appears on the output right after the sample edge.
- R3: Lane 0 slot 0 carries `gpo_in[0]` and slot 1 carries `gpo_in[1]`. Slot 2 carries `fval_in` and slot 3 carries `lval_in`. This holds in every format.
- R4: Data bit mapping: bits 0 to 2 go to lane 0 slots 4 to 6. Bits 3 to 9 go to lane 1 slots 0 to 6, bits 10 to 16 to lane 2, and bits 17 to 23 to lane 3. Data bit n sits in its lane at the slot with the lowest index first.
- R5: `fmt_in` = 2'b00 (8-bit data or frame information): data bits 8 to 23 are sent as zero, and lanes 2 and 3 stay low.
- R6: `fmt_in` = 2'b01 (12-bit) clears data bits 12 to 23. `fmt_in` = 2'b10 (16-bit) clears data bits 16 to 23. In both cases lane 3 stays low.
- R7: `fmt_in` = 2'b11 (24-bit) sends all 24 data bits on all four lanes.
- R8: `wclk_o` is high during the first 4 bit periods of each word and low during the last 3. It rises together with the slot 6 bit.
- R9: Reset is synchronous and active-high. While it is asserted, all lanes and `wclk_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (seven times the word rate) |
| rst | input | 1 | Synchronous active-high reset |
| gpo_in | input | 2 | General-purpose output bits for lane 0 slots 0 and 1 |
| fval_in | input | 1 | Frame-valid sync bit |
| lval_in | input | 1 | Line-valid sync bit |
| data_in | input | 24 | Data channel word |
| fmt_in | input | 2 | Data width select: 00=8, 01=12, 10=16, 11=24 bits |
| lane_o | output | 4 | Serial data lanes, bit k is lane k |
| wclk_o | output | 1 | Word-boundary marker, 4 high and 3 low per word |

## Verification
The bench builds the block with its default geometry: four lanes of seven slots, giving a 24-bit data channel. This brings every format-dependent lane boundary within reach. The 8-bit case cuts lane 1 partway, at slots 5 and 6. The 12-bit case cuts lane 2 after slot 1, and the 16-bit case cuts it after slot 5. Data words with all bits set show whether the mask falls at the right bit. Sideband patterns are varied independently of the data. A mid-word overwrite of every input shows that the latched word alone reaches the lanes.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;

    localparam int LANES    = 4;
    localparam int SLOTS    = 7;
    localparam int SIDE_W   = 4;
    localparam int WORD_W   = LANES * SLOTS;
    localparam int DATA_W   = WORD_W - SIDE_W;
    localparam int CNT_W    = $clog2(SLOTS);
    localparam int HIGH_CNT = (SLOTS + 1) / 2;

    typedef enum logic [1:0] {
        FMT_8  = 2'b00,
        FMT_12 = 2'b01,
        FMT_16 = 2'b10,
        FMT_24 = 2'b11
    } pix_fmt_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              lv;
        logic              fv;
        logic [1:0]        gpo;
    } ser_word_t;

    function automatic int fmt_bits(pix_fmt_e f);
        case (f)
            FMT_8:   return 8;
            FMT_12:  return 12;
            FMT_16:  return 16;
            default: return DATA_W;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] data_mask(pix_fmt_e f);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) m[i] = (i < fmt_bits(f));
        return m;
    endfunction

    function automatic logic [LANES-1:0] lane_enable(pix_fmt_e f);
        logic [LANES-1:0] e;
        for (int k = 0; k < LANES; k++)
            e[k] = (k * SLOTS < SIDE_W + fmt_bits(f));
        return e;
    endfunction

endpackage

// File: rtl/pix_word_map.sv
module pix_word_map
    import pix_ser_pkg::*;
(
    input  ser_word_t              word_i,
    input  pix_fmt_e               fmt_i,
    output logic [LANES*SLOTS-1:0] lanes_o
);
    ser_word_t          masked;
    logic [LANES-1:0]   en;

    always_comb begin
        masked      = word_i;
        masked.data = word_i.data & data_mask(fmt_i);
        en          = lane_enable(fmt_i);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lanes_o[k*SLOTS +: SLOTS] = masked[k*SLOTS +: SLOTS] & {SLOTS{en[k]}};
    end
endmodule

// File: rtl/pix_lane_shift.sv
module pix_lane_shift
    import pix_ser_pkg::*;
#(
    parameter int W = SLOTS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] par_i,
    output logic         ser_o
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst)       sreg <= '0;
        else if (load) sreg <= par_i;
        else           sreg <= {sreg[W-2:0], 1'b0};
    end

    assign ser_o = sreg[W-1];
endmodule

// File: rtl/pix_word_timer.sv
module pix_word_timer
    import pix_ser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic load_o,
    output logic wclk_o
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            wclk_o <= 1'b0;
        end else begin
            cnt    <= (cnt == CNT_W'(SLOTS-1)) ? '0 : cnt + 1'b1;
            wclk_o <= (cnt < CNT_W'(HIGH_CNT));
        end
    end

    assign load_o = ~rst & (cnt == '0);

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(SLOTS-1));
    assert_load_period_R1: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !load_o);
    assert_wclk_rise_R8: assert property (@(posedge clk) disable iff (rst)
        load_o |=> wclk_o);
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
    import pix_ser_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  gpo_in,
    input  logic        fval_in,
    input  logic        lval_in,
    input  logic [23:0] data_in,
    input  logic [1:0]  fmt_in,
    output logic [3:0]  lane_o,
    output logic        wclk_o
);
    ser_word_t              word;
    logic [LANES*SLOTS-1:0] lane_par;
    logic                   load;
    pix_fmt_e               fmt_q;

    always_comb begin
        word.gpo  = gpo_in;
        word.fv   = fval_in;
        word.lv   = lval_in;
        word.data = data_in;
    end

    pix_word_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_o (load),
        .wclk_o (wclk_o)
    );

    pix_word_map u_map (
        .word_i  (word),
        .fmt_i   (pix_fmt_e'(fmt_in)),
        .lanes_o (lane_par)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_ser
        pix_lane_shift #(.W(SLOTS)) u_shift (
            .clk   (clk),
            .rst   (rst),
            .load  (load),
            .par_i (lane_par[k*SLOTS +: SLOTS]),
            .ser_o (lane_o[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)       fmt_q <= FMT_8;
        else if (load) fmt_q <= pix_fmt_e'(fmt_in);
    end

    assert_narrow_lanes_R5: assert property (@(posedge clk) disable iff (rst)
        (fmt_q == FMT_8) |-> (lane_o[3:2] == 2'b00));
    assert_mid_lanes_R6: assert property (@(posedge clk) disable iff (rst)
        (fmt_q == FMT_12 || fmt_q == FMT_16) |-> (lane_o[3] == 1'b0));
    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> (lane_o == 4'b0 && !wclk_o));
endmodule

// File: tb/pix_serializer_bench.sv
module pix_serializer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  gpo_in = '0;
    logic        fval_in = 1'b0;
    logic        lval_in = 1'b0;
    logic [23:0] data_in = '0;
    logic [1:0]  fmt_in = '0;
    logic [3:0]  lane_o;
    logic        wclk_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pix_serializer u_pix_serializer (
        .clk(clk), .rst(rst), .gpo_in(gpo_in), .fval_in(fval_in),
        .lval_in(lval_in), .data_in(data_in), .fmt_in(fmt_in),
        .lane_o(lane_o), .wclk_o(wclk_o)
    );

    function automatic logic [6:0] exp_lane(int k, logic [1:0] g, logic fv, logic lv,
                                            logic [23:0] d, logic [1:0] f);
        logic [23:0] m;
        logic [27:0] flat;
        int          top;
        top  = (f == 2'b00) ? 8 : (f == 2'b01) ? 12 : (f == 2'b10) ? 16 : 24;
        m    = d;
        for (int i = 0; i < 24; i++) if (i >= top) m[i] = 1'b0;
        flat = {m, lv, fv, g[1], g[0]};
        if ((f == 2'b00 && k >= 2) || ((f == 2'b01 || f == 2'b10) && k == 3))
            return 7'b0;
        return flat[k*7 +: 7];
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_word(string req, logic [1:0] g, logic fv, logic lv,
                             logic [23:0] d, logic [1:0] f, bit scramble);
        logic [6:0] got [4];
        logic [6:0] wpat;
        for (int k = 0; k < 4; k++) got[k] = '0;
        wpat = '0;
        gpo_in = g; fval_in = fv; lval_in = lv; data_in = d; fmt_in = f;
        for (int s = 0; s < 7; s++) begin
            @(posedge clk);
            @(negedge clk);
            for (int k = 0; k < 4; k++) got[k] = {got[k][5:0], lane_o[k]};
            wpat = {wpat[5:0], wclk_o};
            if (scramble && s == 1) begin
                gpo_in = ~g; fval_in = ~fv; lval_in = ~lv; data_in = ~d; fmt_in = ~f;
            end
        end
        for (int k = 0; k < 4; k++)
            check(req, $sformatf("lane %0d", k), 32'(got[k]), 32'(exp_lane(k, g, fv, lv, d, f)));
        check("R8", "wclk pattern", 32'(wpat), 32'(7'b1111000));
    endtask

    task automatic test_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", "lanes in reset", 32'(lane_o), 32'h0);
        check("R9", "wclk in reset", 32'(wclk_o), 32'h0);
        rst = 1'b0;
    endtask

    task automatic test_sideband_R3();
        send_word("R3", 2'b01, 1'b1, 1'b0, 24'h000000, 2'b11, 1'b0);
        send_word("R3", 2'b10, 1'b0, 1'b1, 24'h000000, 2'b00, 1'b0);
    endtask

    task automatic test_map_R4();
        send_word("R4", 2'b00, 1'b0, 1'b0, 24'h000001, 2'b11, 1'b0);
        send_word("R4", 2'b00, 1'b0, 1'b0, 24'h020408, 2'b11, 1'b0);
        send_word("R2", 2'b11, 1'b1, 1'b0, 24'h5A3C96, 2'b11, 1'b0);
    endtask

    task automatic test_fmt8_R5();
        send_word("R5", 2'b11, 1'b1, 1'b1, 24'hFFFFFF, 2'b00, 1'b0);
        send_word("R5", 2'b00, 1'b1, 1'b0, 24'hABCD5A, 2'b00, 1'b0);
    endtask

    task automatic test_fmt12_16_R6();
        send_word("R6", 2'b01, 1'b0, 1'b1, 24'hFFFFFF, 2'b01, 1'b0);
        send_word("R6", 2'b10, 1'b1, 1'b1, 24'hFFFFFF, 2'b10, 1'b0);
        send_word("R6", 2'b00, 1'b1, 1'b0, 24'h96E71B, 2'b10, 1'b0);
    endtask

    task automatic test_fmt24_R7();
        send_word("R7", 2'b11, 1'b1, 1'b1, 24'hFFFFFF, 2'b11, 1'b0);
        send_word("R7", 2'b01, 1'b0, 1'b0, 24'h800000, 2'b11, 1'b0);
    endtask

    task automatic test_hold_R1();
        send_word("R1", 2'b10, 1'b1, 1'b0, 24'h13579B, 2'b11, 1'b1);
        send_word("R1", 2'b01, 1'b0, 1'b1, 24'h0000F0, 2'b00, 1'b1);
    endtask

    initial begin
        test_reset();
        test_sideband_R3();
        test_map_R4();
        test_fmt8_R5();
        test_fmt12_16_R6();
        test_fmt24_R7();
        test_hold_R1();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule